// File: doc/BRIEF.md
# Lockable Software Reset Controller

This block gives software two kinds of reset control through a small register port. The first is a bank of peripheral reset channels. Each channel has an active-low reset output that follows a control bit. Next to each control bit sits a lock bit. Software can clear a lock but cannot set it again, so once a channel is locked its reset state is fixed until the block itself is reset.

The second is a whole-system reset request sent to a power controller. The request is held in a 4-bit field that uses a redundant true/false encoding. Writing the encoded true value raises the request. When the power controller reports through the reset-done input that the reset has finished, hardware puts the field back to false. The request output is registered and only ever shows one of the two legal codes.

Register writes take effect on the next clock edge. Reads are combinational from the current register state. Synchronizing each reset into the peripherals' own clock domains is left to the logic that receives them.

Top module: `swrst_ctl`

## Requirements
- R1: After reset every `periph_rst_no` bit is 1, every lock bit reads 1, the request field reads 0x9 and `sys_req_o` is 0x9.
- R2: A write to the control register of an unlocked channel stores bit 0 of the write data. `periph_rst_no[i]` shows that value from the clock edge that takes the write, where 0 holds the peripheral in reset and 1 releases it.
- R3: Writing 0 in bit 0 of a lock register clears that lock. Writing 1 leaves it unchanged, and a cleared lock never returns to 1 before the next reset.
- R4: While a channel's lock is 0, writes to its control register leave the control bit and the reset output unchanged.
- R5: Writing 0x6 (true) to the request field drives `sys_req_o` to 0x6 from the clock edge that takes the write.
- R6: `sys_done_i` high at a clock edge sets the request field and `sys_req_o` to 0x9 at that edge. It wins over a write to the field in the same cycle.
- R7: Any field value other than 0x6 is no request, so `sys_req_o` is 0x9. The field reads back the 4-bit value last written. `sys_req_o` is always 0x6 or 0x9.
- R8: Reserved bits read as 0. Reads of unmapped addresses return 0, and writes to them change nothing.
- R9: Address map (6-bit word address, region in bits 5:4, channel index in bits 3:0): 0x00 is the request field in bits 3:0. 0x10+i is the lock of channel i in bit 0. 0x20+i is the control of channel i in bit 0. At most one register is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| periph_rst_no | output | 8 | Active-low peripheral reset outputs |
| sys_req_o | output | 4 | System reset request, 0x6 true, 0x9 false |
| sys_done_i | input | 1 | Requested system reset has completed |

## Verification
Every result of a write or of `sys_done_i` is due at the single clock edge that samples the stimulus. This covers the reset outputs, the request output and the read-back. Read data is due as soon as the address settles. The bench drives stimulus on the falling edge and compares outputs and all register read-backs one nanosecond after the following rising edge, against a model updated by the requirement rules. Random operations are mixed with directed cases: a write arriving together with done, illegal field codes, writes to locked channels, and unmapped addresses.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
    localparam logic [3:0] MB_TRUE  = 4'h6;
    localparam logic [3:0] MB_FALSE = 4'h9;

    typedef enum logic [1:0] {
        RG_SYS  = 2'd0,
        RG_LOCK = 2'd1,
        RG_CTRL = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic lock;
        logic ctrl;
    } chan_st_t;

    typedef struct packed {
        logic [3:0] field;
        logic [3:0] req;
    } sys_st_t;
endpackage

// File: rtl/swrst_chan.sv
module swrst_chan
    import swrst_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lock_we_i,
    input  logic ctrl_we_i,
    input  logic wbit_i,
    output logic lock_o,
    output logic ctrl_o
);
    chan_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (lock_we_i && !wbit_i) begin
            s_d.lock = 1'b0;
        end
        if (ctrl_we_i && s_q.lock) begin
            s_d.ctrl = wbit_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{lock: 1'b1, ctrl: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_o = s_q.lock;
    assign ctrl_o = s_q.ctrl;

    // R3: a cleared lock never comes back
    assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.lock |=> !s_q.lock);

    // R4: locked channel keeps its control bit
    assert_locked_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.lock |=> $stable(ctrl_o));

    // R2: unlocked write lands on the next edge
    assert_ctrl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_we_i && lock_o) |=> (ctrl_o == $past(wbit_i)));
endmodule

// File: rtl/swrst_sysreq.sv
module swrst_sysreq
    import swrst_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       we_i,
    input  logic [3:0] wdata_i,
    input  logic       done_i,
    output logic [3:0] field_o,
    output logic [3:0] req_o
);
    sys_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (done_i) begin
            s_d.field = MB_FALSE;
        end else if (we_i) begin
            s_d.field = wdata_i;
        end
        s_d.req = (s_d.field == MB_TRUE) ? MB_TRUE : MB_FALSE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{field: MB_FALSE, req: MB_FALSE};
        end else begin
            s_q <= s_d;
        end
    end

    assign field_o = s_q.field;
    assign req_o   = s_q.req;

    // R5: a true write raises the request
    assert_req_raise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !done_i && wdata_i == MB_TRUE) |=> (req_o == MB_TRUE));

    // R6: done restores false, overriding a write
    assert_done_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> (req_o == MB_FALSE && field_o == MB_FALSE));

    // R7: only legal codes reach the output
    assert_req_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o == MB_TRUE) || (req_o == MB_FALSE));
endmodule

// File: rtl/swrst_regif.sv
module swrst_regif
    import swrst_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 6,
    parameter int DW  = 32
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           we_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [NCH-1:0] lock_i,
    input  logic [NCH-1:0] ctrl_i,
    input  logic [3:0]     field_i,
    output logic [NCH-1:0] lock_we_o,
    output logic [NCH-1:0] ctrl_we_o,
    output logic           sys_we_o,
    output logic [DW-1:0]  rdata_o
);
    localparam int IW = AW - 2;

    region_e       region;
    logic [IW-1:0] idx;

    assign region = region_e'(addr_i[AW-1:AW-2]);
    assign idx    = addr_i[IW-1:0];

    always_comb begin
        lock_we_o = '0;
        ctrl_we_o = '0;
        sys_we_o  = we_i && (region == RG_SYS) && (idx == '0);
        rdata_o   = '0;
        if ((region == RG_SYS) && (idx == '0)) begin
            rdata_o[3:0] = field_i;
        end
        for (int i = 0; i < NCH; i++) begin
            if (idx == i[IW-1:0]) begin
                if (region == RG_LOCK) begin
                    lock_we_o[i] = we_i;
                    rdata_o[0]   = lock_i[i];
                end
                if (region == RG_CTRL) begin
                    ctrl_we_o[i] = we_i;
                    rdata_o[0]   = ctrl_i[i];
                end
            end
        end
    end

    // R9: at most one register written per cycle
    assert_one_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({lock_we_o, ctrl_we_o, sys_we_o}));

    // R8: no write strobe without a write
    assert_no_stray_we_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |-> ({lock_we_o, ctrl_we_o, sys_we_o} == '0));
endmodule

// File: rtl/swrst_ctl.sv
module swrst_ctl
    import swrst_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 6,
    parameter int DW  = 32
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           reg_we_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    output logic [NCH-1:0] periph_rst_no,
    output logic [3:0]     sys_req_o,
    input  logic           sys_done_i
);
    logic [NCH-1:0] lock_we, ctrl_we, lock_v, ctrl_v;
    logic           sys_we;
    logic [3:0]     field;
    logic           unused_wbits;

    assign unused_wbits = ^reg_wdata_i[DW-1:4];

    swrst_regif #(.NCH(NCH), .AW(AW), .DW(DW)) u_regif (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .lock_i    (lock_v),
        .ctrl_i    (ctrl_v),
        .field_i   (field),
        .lock_we_o (lock_we),
        .ctrl_we_o (ctrl_we),
        .sys_we_o  (sys_we),
        .rdata_o   (reg_rdata_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        swrst_chan u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .lock_we_i (lock_we[g]),
            .ctrl_we_i (ctrl_we[g]),
            .wbit_i    (reg_wdata_i[0]),
            .lock_o    (lock_v[g]),
            .ctrl_o    (ctrl_v[g])
        );
    end

    swrst_sysreq u_sysreq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (sys_we),
        .wdata_i (reg_wdata_i[3:0]),
        .done_i  (sys_done_i),
        .field_o (field),
        .req_o   (sys_req_o)
    );

    assign periph_rst_no = ctrl_v;

    // R1: outputs leave reset released and not requesting
    assert_reset_state_R1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (periph_rst_no == '1 && sys_req_o == MB_FALSE));
endmodule

// File: tb/swrst_ctl_tb.sv
module swrst_ctl_tb;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] prst_n;
    logic [3:0]  req;
    logic        done = 1'b0;

    int total = 0;
    int bad = 0;

    logic       m_lock [NCH];
    logic       m_ctrl [NCH];
    logic [3:0] m_field;

    always #4 clk = ~clk;

    swrst_ctl u_dut (
        .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_addr_i (addr),
        .reg_wdata_i (wdata), .reg_rdata_o (rdata), .periph_rst_no (prst_n),
        .sys_req_o (req), .sys_done_i (done)
    );

    function automatic logic [3:0] exp_req(input logic [3:0] f);
        return (f == 4'h6) ? 4'h6 : 4'h9;
    endfunction

    function automatic logic [NCH-1:0] exp_rst();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = m_ctrl[i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_lock[i] = 1'b1;
            m_ctrl[i] = 1'b1;
        end
        m_field = 4'h9;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        we = 1'b0;
        done = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic model_write(input logic [5:0] a, input logic [31:0] d, input logic dn);
        if (a[5:4] == 2'd0 && a[3:0] == 4'd0 && !dn) m_field = d[3:0];
        if (a[5:4] == 2'd1 && a[3:0] < NCH && !d[0]) m_lock[a[2:0]] = 1'b0;
        if (a[5:4] == 2'd2 && a[3:0] < NCH && m_lock[a[2:0]]) m_ctrl[a[2:0]] = d[0];
        if (dn) m_field = 4'h9;
    endtask

    task automatic op(input logic w, input logic [5:0] a, input logic [31:0] d, input logic dn);
        @(negedge clk);
        we = w;
        addr = a;
        wdata = d;
        done = dn;
        @(posedge clk);
        if (w) model_write(a, d, 1'b0);
        if (dn) m_field = 4'h9;
        #1;
        we = 1'b0;
        done = 1'b0;
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " R2 rst outputs"}, 32'(prst_n), 32'(exp_rst()));
        chk({tag, " R7 request output"}, 32'(req), 32'(exp_req(m_field)));
    endtask

    task automatic check_readback(input string tag);
        addr = 6'h00;
        #1 chk({tag, " R7 field readback"}, rdata, {28'b0, m_field});
        for (int i = 0; i < NCH; i++) begin
            addr = 6'h10 + 6'(i);
            #1 chk({tag, " R3 lock readback"}, rdata, {31'b0, m_lock[i]});
            addr = 6'h20 + 6'(i);
            #1 chk({tag, " R4 ctrl readback"}, rdata, {31'b0, m_ctrl[i]});
        end
        addr = 6'h30;
        #1 chk({tag, " R8 unmapped read"}, rdata, 32'h0);
        addr = 6'h18;
        #1 chk({tag, " R8 index past channels"}, rdata, 32'h0);
    endtask

    initial begin
        #150000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rnd;
        void'($urandom(32'd1234));
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset rst outputs", 32'(prst_n), 32'hFF);
        chk("R1 reset request", 32'(req), 32'h9);
        check_readback("R1 reset");

        // R2 directed: hold channel 3 in reset then release
        op(1'b1, 6'h23, 32'hFFFF_FFFE, 1'b0);
        chk("R2 ch3 held", 32'(prst_n[3]), 32'h0);
        op(1'b1, 6'h23, 32'h0000_0001, 1'b0);
        chk("R2 ch3 released", 32'(prst_n[3]), 32'h1);

        // R3/R4 directed: lock channel 5 while in reset
        op(1'b1, 6'h25, 32'h0, 1'b0);
        op(1'b1, 6'h15, 32'h1, 1'b0);
        chk("R3 lock write 1 ignored", 32'(m_lock[5]), 32'h1);
        op(1'b1, 6'h15, 32'h0, 1'b0);
        op(1'b1, 6'h25, 32'h1, 1'b0);
        chk("R4 locked ch5 stays", 32'(prst_n[5]), 32'h0);
        op(1'b1, 6'h15, 32'h1, 1'b0);
        check_readback("R3 lock sticky");

        // R5/R6/R7 directed
        op(1'b1, 6'h00, 32'hFFFF_FFF6, 1'b0);
        chk("R5 request raised", 32'(req), 32'h6);
        op(1'b0, 6'h00, 32'h0, 1'b1);
        chk("R6 done clears", 32'(req), 32'h9);
        op(1'b1, 6'h00, 32'h6, 1'b1);
        chk("R6 done beats write", 32'(req), 32'h9);
        op(1'b1, 6'h00, 32'h7, 1'b0);
        chk("R7 illegal code no request", 32'(req), 32'h9);
        check_readback("R7 illegal code");

        // R8/R9: unmapped writes change nothing
        op(1'b1, 6'h30, 32'h0, 1'b0);
        op(1'b1, 6'h01, 32'h6, 1'b0);
        op(1'b1, 6'h19, 32'h0, 1'b0);
        op(1'b1, 6'h2A, 32'h0, 1'b0);
        check_outputs("R8 unmapped writes");
        check_readback("R9 map");

        do_reset();
        chk("R1 second reset outputs", 32'(prst_n), 32'hFF);
        check_readback("R1 second reset");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [5:0] a;
            logic       dn;
            rnd = $urandom();
            case (rnd[2:0])
                3'd0, 3'd1: a = {2'd2, 1'b0, rnd[5:3]};
                3'd2:       a = {2'd1, 1'b0, rnd[5:3]};
                3'd3, 3'd4: a = 6'h00;
                default:    a = 6'(rnd[13:8]);
            endcase
            rnd = $urandom();
            if (a[5:4] == 2'd1 && rnd[7:4] != 4'd0) rnd[0] = 1'b1;
            if (a == 6'h00 && rnd[8]) rnd[3:0] = 4'h6;
            dn = ($urandom_range(0, 7) == 0);
            op(($urandom_range(0, 3) != 0), a, rnd, dn);
            check_outputs("random");
            if (n % 50 == 0) check_readback("random");
            if (n == 300) do_reset();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule